// File: doc/BRIEF.md
# Core-to-Host Message Channel Unit

This block gives a processor core a handful of small, blocking message channels to and from a host. The host pushes 32-bit words into a four-deep inbound queue. The core drains that queue through a channel read port. The core posts words into two single-word outbound slots, and the host collects them. Posting into the second slot holds an interrupt line high toward the host until the host collects the word.

Two 32-bit signal registers carry host-to-core notifications. Each register can replace its contents on every host write, or it can OR each write into what it already holds, so that several senders can set separate bits. A core read returns the held value and clears the register.

Every channel reports an occupancy count. When a core request cannot complete, a stall output is raised in the same cycle. The core holds its request until the stall drops, and the operation completes on that clock edge.

Top module: `msgchan_unit`

## Requirements
- R1: After reset the inbound count is 0, both outbound slots report one free place (outFree = 2'b11), both signal counts are 0, and mboxIrq and inboxOverflow are 0.
- R2: Each host inbound write adds one word, and the new count shows from the next cycle. A core read with coreRdSel = 0 returns the oldest word on coreRdData in the same cycle and removes it at the clock edge.
- R3: A core read with coreRdSel = 0 while the inbound count is 0 raises coreStall and changes nothing. Once the count is nonzero, the held request completes.
- R4: A host inbound write while the queue holds four words and no core read takes a word in that cycle replaces the newest word. The count stays at 4, and inboxOverflow is set and stays set until reset.
- R5: A host inbound write in the same cycle as a completing core read of a full queue is a normal write. The count stays at 4, and inboxOverflow does not change.
- R6: A core write with coreWrSel = 0 or 1 loads outbound slot 0 or 1. The slot's outFree bit falls to 0 and its hostOut data shows the word from the next cycle. A host read pulse on hostOutRd[i] frees slot i; a pulse on an empty slot has no effect.
- R7: A core write to a full outbound slot raises coreStall and leaves the held word unchanged, even in a cycle where the host reads that slot.
- R8: mboxIrq is high exactly while outbound slot 1 holds a word. Slot 0 never raises it.
- R9: With sigOrMode[i] = 0, a host write on hostSigWr[i] replaces signal register i. sigCount[i] is 1 exactly when the register is nonzero, so writing zero leaves the count at 0.
- R10: With sigOrMode[i] = 1, a host write ORs hostWrData into signal register i.
- R11: A core read with coreRdSel = 1 (register 0) or 2 (register 1) returns the held value and clears the register to zero. A read of a zero register stalls. coreRdSel = 3 selects nothing: it never stalls and returns zero.
- R12: A host write to a signal register in the same cycle as a completing core read of it leaves the register holding hostWrData, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostInboxWr | input | 1 | Host write strobe into the inbound queue |
| hostWrData | input | 32 | Host write data for the queue and signal registers |
| hostSigWr | input | 2 | Host write strobes, one per signal register |
| sigOrMode | input | 2 | Per signal register: 1 = OR-accumulate, 0 = replace |
| hostOutRd | input | 2 | Host read pulses, one per outbound slot |
| hostOut0Data | output | 32 | Word held in outbound slot 0 |
| hostOut1Data | output | 32 | Word held in outbound slot 1 |
| coreRdReq | input | 1 | Core channel read request |
| coreRdSel | input | 2 | Read channel: 0 inbound, 1 signal 0, 2 signal 1, 3 none |
| coreRdData | output | 32 | Read data for the selected channel |
| coreWrReq | input | 1 | Core channel write request |
| coreWrSel | input | 1 | Write channel: 0 slot 0, 1 interrupting slot 1 |
| coreWrData | input | 32 | Core write data |
| coreStall | output | 1 | Core request cannot complete this cycle |
| inboxCount | output | 3 | Words waiting in the inbound queue |
| outFree | output | 2 | Free places per outbound slot (1 = empty) |
| sigCount | output | 2 | Per signal register: 1 when it holds a nonzero value |
| mboxIrq | output | 1 | Level interrupt while slot 1 is full |
| inboxOverflow | output | 1 | Sticky flag: a host write replaced an unread word |

## Verification
coreStall and coreRdData come from combinational logic, so they are due in the same cycle as the request. The bench compares them about one time unit after driving the inputs, which is before the clock edge that commits the operation. Counts, the overflow flag, mboxIrq and the outbound data are registered and change at the first clock edge after the stimulus. The bench therefore compares them on the following cycle, against a behavioural model whose state it advances only after that cycle's comparison.

// File: rtl/msgchan_pkg.sv
package msgchan_pkg;
  typedef enum logic [1:0] {
    RD_INBOX = 2'd0,
    RD_SIG0  = 2'd1,
    RD_SIG1  = 2'd2,
    RD_NONE  = 2'd3
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       inWrEn;   // write inbound storage at wrIdx
    logic [1:0] sigLoad;  // host write per signal register
    logic [1:0] sigClr;   // core read clears per signal register
    logic [1:0] outLoad;  // core write per outbound slot
  } strobes_t;
endpackage

// File: rtl/msgchan_ctrl.sv
module msgchan_ctrl
  import msgchan_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostInboxWr,
  input  logic [1:0]       hostSigWr,
  input  logic [1:0]       hostOutRd,
  input  logic             coreRdReq,
  input  logic [1:0]       coreRdSel,
  input  logic             coreWrReq,
  input  logic             coreWrSel,
  input  logic [1:0]       sigNonzero,
  output strobes_t         stb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [CNT_W-1:0] inboxCount,
  output logic [1:0]       outFree,
  output logic [1:0]       sigCount,
  output logic             mboxIrq,
  output logic             inboxOverflow,
  output logic             coreStall
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] inCnt;
  logic [1:0]       outFull;
  logic             ovf;
  logic             inEmpty, inFull, inPop, inPush, inOverwrite;
  logic             rdBlocked, wrBlocked;
  logic [1:0]       sigRd;
  rdSel_e           sel;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign sel     = rdSel_e'(coreRdSel);
  assign inEmpty = (inCnt == '0);
  assign inFull  = (inCnt == FULL);

  always_comb begin
    rdBlocked = 1'b0;
    if (coreRdReq) begin
      case (sel)
        RD_INBOX: rdBlocked = inEmpty;
        RD_SIG0:  rdBlocked = !sigNonzero[0];
        RD_SIG1:  rdBlocked = !sigNonzero[1];
        default:  rdBlocked = 1'b0;
      endcase
    end
  end

  assign wrBlocked   = coreWrReq && outFull[coreWrSel];
  assign coreStall   = rdBlocked || wrBlocked;

  assign inPop       = coreRdReq && (sel == RD_INBOX) && !rdBlocked;
  assign inPush      = hostInboxWr && (!inFull || inPop);
  assign inOverwrite = hostInboxWr && inFull && !inPop;
  assign sigRd[0]    = coreRdReq && (sel == RD_SIG0) && !rdBlocked;
  assign sigRd[1]    = coreRdReq && (sel == RD_SIG1) && !rdBlocked;

  always_comb begin
    stb         = '0;
    stb.inWrEn  = hostInboxWr;
    stb.sigLoad = hostSigWr;
    stb.sigClr  = sigRd;
    if (coreWrReq && !wrBlocked) stb.outLoad[coreWrSel] = 1'b1;
  end

  assign wrIdx = inOverwrite ? ((wrPtr == '0) ? LAST : wrPtr - 1'b1) : wrPtr;
  assign rdIdx = rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      inCnt <= '0;
      ovf   <= 1'b0;
    end else begin
      if (inPush) wrPtr <= nextPtr(wrPtr);
      if (inPop)  rdPtr <= nextPtr(rdPtr);
      case ({inPush, inPop})
        2'b10:   inCnt <= inCnt + 1'b1;
        2'b01:   inCnt <= inCnt - 1'b1;
        default: inCnt <= inCnt;
      endcase
      if (inOverwrite) ovf <= 1'b1;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : gOut
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               outFull[i] <= 1'b0;
      else if (stb.outLoad[i]) outFull[i] <= 1'b1;
      else if (hostOutRd[i])   outFull[i] <= 1'b0;
    end
  end

  assign inboxCount    = inCnt;
  assign outFree       = ~outFull;
  assign sigCount      = sigNonzero;
  assign mboxIrq       = outFull[1];
  assign inboxOverflow = ovf;
endmodule

// File: rtl/msgchan_dpath.sv
module msgchan_dpath
  import msgchan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [1:0]        sigOrMode,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic [1:0]        coreRdSel,
  output logic [DATA_W-1:0] coreRdData,
  output logic [DATA_W-1:0] hostOut0Data,
  output logic [DATA_W-1:0] hostOut1Data,
  output logic [1:0]        sigNonzero
);
  logic [DATA_W-1:0] inMem   [DEPTH];
  logic [DATA_W-1:0] sigVal  [2];
  logic [DATA_W-1:0] outData [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) inMem[k] <= '0;
    end else if (stb.inWrEn) begin
      inMem[wrIdx] <= hostWrData;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : gChan
    logic [DATA_W-1:0] sigBase, sigNext;
    always_comb begin
      sigBase = stb.sigClr[i] ? '0 : sigVal[i];
      sigNext = sigBase;
      if (stb.sigLoad[i]) sigNext = sigOrMode[i] ? (sigBase | hostWrData) : hostWrData;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sigVal[i] <= '0;
      else       sigVal[i] <= sigNext;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               outData[i] <= '0;
      else if (stb.outLoad[i]) outData[i] <= coreWrData;
    end
    assign sigNonzero[i] = |sigVal[i];
  end

  always_comb begin
    case (rdSel_e'(coreRdSel))
      RD_INBOX: coreRdData = inMem[rdIdx];
      RD_SIG0:  coreRdData = sigVal[0];
      RD_SIG1:  coreRdData = sigVal[1];
      default:  coreRdData = '0;
    endcase
  end

  assign hostOut0Data = outData[0];
  assign hostOut1Data = outData[1];
endmodule

// File: rtl/msgchan_unit.sv
module msgchan_unit
  import msgchan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostInboxWr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [1:0]        hostSigWr,
  input  logic [1:0]        sigOrMode,
  input  logic [1:0]        hostOutRd,
  output logic [DATA_W-1:0] hostOut0Data,
  output logic [DATA_W-1:0] hostOut1Data,
  input  logic              coreRdReq,
  input  logic [1:0]        coreRdSel,
  output logic [DATA_W-1:0] coreRdData,
  input  logic              coreWrReq,
  input  logic              coreWrSel,
  input  logic [DATA_W-1:0] coreWrData,
  output logic              coreStall,
  output logic [CNT_W-1:0]  inboxCount,
  output logic [1:0]        outFree,
  output logic [1:0]        sigCount,
  output logic              mboxIrq,
  output logic              inboxOverflow
);
  strobes_t         stb;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  logic [1:0]       sigNonzero;

  msgchan_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) uCtrl (
    .clk, .rstN, .hostInboxWr, .hostSigWr, .hostOutRd, .coreRdReq, .coreRdSel,
    .coreWrReq, .coreWrSel, .sigNonzero, .stb, .wrIdx, .rdIdx, .inboxCount,
    .outFree, .sigCount, .mboxIrq, .inboxOverflow, .coreStall
  );

  msgchan_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) uDpath (
    .clk, .rstN, .stb, .wrIdx, .rdIdx, .hostWrData, .sigOrMode, .coreWrData,
    .coreRdSel, .coreRdData, .hostOut0Data, .hostOut1Data, .sigNonzero
  );
endmodule

// File: rtl/msgchan_chk.sv
module msgchan_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       hostOutRd,
  input logic [1:0]       hostSigWr,
  input logic             coreRdReq,
  input logic [1:0]       coreRdSel,
  input logic             coreWrReq,
  input logic             coreWrSel,
  input logic             coreStall,
  input logic [31:0]      hostOut0Data,
  input logic [CNT_W-1:0] inboxCount,
  input logic [1:0]       outFree,
  input logic [1:0]       sigCount,
  input logic             mboxIrq,
  input logic             inboxOverflow
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    inboxCount <= CNT_W'(DEPTH));

  a_r3_stall_empty: assert property (@(posedge clk) disable iff (!rstN)
    (coreRdReq && coreRdSel == 2'd0 && inboxCount == '0) |-> coreStall);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    inboxOverflow |=> inboxOverflow);

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!outFree[0] && !hostOutRd[0]) |=> $stable(hostOut0Data));

  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrReq && coreWrSel && !coreStall) |=> mboxIrq);

  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (hostOutRd[1] && !(coreWrReq && coreWrSel && !coreStall)) |=> !mboxIrq);

  a_r11_sig_clear: assert property (@(posedge clk) disable iff (!rstN)
    (coreRdReq && coreRdSel == 2'd1 && !coreStall && !hostSigWr[0]) |=> (sigCount[0] == 1'b0));
endmodule

bind msgchan_unit msgchan_chk #(.DEPTH(DEPTH)) uChk (.*);

// File: tb/msgchan_unit_test.sv
`timescale 1ns/1ps
module msgchan_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostInboxWr = 0;
  logic [31:0] hostWrData = 0;
  logic [1:0]  hostSigWr = 0, sigOrMode = 0, hostOutRd = 0;
  logic [31:0] hostOut0Data, hostOut1Data, coreRdData;
  logic        coreRdReq = 0;
  logic [1:0]  coreRdSel = 0;
  logic        coreWrReq = 0, coreWrSel = 0;
  logic [31:0] coreWrData = 0;
  logic        coreStall, mboxIrq, inboxOverflow;
  logic [2:0]  inboxCount;
  logic [1:0]  outFree, sigCount;

  msgchan_unit uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] mq[$];
  bit          mOvf = 0;
  bit          mOutV [2] = '{0, 0};
  logic [31:0] mOutD [2] = '{0, 0};
  logic [31:0] mSig  [2] = '{0, 0};

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    hostInboxWr = 0; hostSigWr = 0; hostOutRd = 0;
    coreRdReq = 0; coreWrReq = 0;
  endtask

  // compare this cycle, advance the model, move to the next negedge
  task automatic cyc();
    bit rdBlk, wrBlk, rdGo;
    logic [31:0] v;
    #1;
    rdBlk = 0;
    if (coreRdReq) begin
      if (coreRdSel == 0) rdBlk = (mq.size() == 0);
      else if (coreRdSel == 1) rdBlk = (mSig[0] == 0);
      else if (coreRdSel == 2) rdBlk = (mSig[1] == 0);
    end
    wrBlk = coreWrReq && mOutV[coreWrSel];
    chk("inboxCount", 32'(inboxCount), 32'(mq.size()));
    chk("inboxOverflow", 32'(inboxOverflow), 32'(mOvf));
    chk("outFree", 32'(outFree), {30'd0, !mOutV[1], !mOutV[0]});
    chk("sigCount", 32'(sigCount), {30'd0, mSig[1] != 0, mSig[0] != 0});
    chk("mboxIrq", 32'(mboxIrq), 32'(mOutV[1]));
    chk("coreStall", 32'(coreStall), 32'(rdBlk || wrBlk));
    if (mOutV[0]) chk("hostOut0Data", hostOut0Data, mOutD[0]);
    if (mOutV[1]) chk("hostOut1Data", hostOut1Data, mOutD[1]);
    rdGo = coreRdReq && !rdBlk;
    if (rdGo) begin
      case (coreRdSel)
        2'd0: v = mq[0];
        2'd1: v = mSig[0];
        2'd2: v = mSig[1];
        default: v = 0;
      endcase
      chk("coreRdData", coreRdData, v);
    end
    // model update
    if (hostInboxWr) begin
      if (mq.size() == 4 && !(rdGo && coreRdSel == 0)) begin
        mq[mq.size()-1] = hostWrData;
        mOvf = 1;
      end else begin
        if (rdGo && coreRdSel == 0) void'(mq.pop_front());
        mq.push_back(hostWrData);
      end
    end else if (rdGo && coreRdSel == 0) void'(mq.pop_front());
    for (int i = 0; i < 2; i++) begin
      v = (rdGo && coreRdSel == 2'(i + 1)) ? 32'd0 : mSig[i];
      if (hostSigWr[i]) v = sigOrMode[i] ? (v | hostWrData) : hostWrData;
      mSig[i] = v;
      if (hostOutRd[i]) mOutV[i] = 0;
    end
    if (coreWrReq && !wrBlk) begin
      mOutV[coreWrSel] = 1;
      mOutD[coreWrSel] = coreWrData;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostPush(input logic [31:0] d);
    idle(); hostInboxWr = 1; hostWrData = d; cyc(); idle();
  endtask

  task automatic coreRead(input logic [1:0] s);
    idle(); coreRdReq = 1; coreRdSel = s; cyc(); idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, R1..R12 run incomplete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    curReq = "R1"; cyc(); cyc();

    // R2 FIFO order
    curReq = "R2";
    hostPush(32'hA0000001); hostPush(32'hA0000002); hostPush(32'hA0000003);
    coreRead(0); coreRead(0); coreRead(0); cyc();

    // R3 blocking read on empty
    curReq = "R3";
    idle(); coreRdReq = 1; coreRdSel = 0; cyc(); cyc();
    hostInboxWr = 1; hostWrData = 32'hB0000001; cyc();
    hostInboxWr = 0; cyc(); idle(); cyc();

    // R5 push and pop while full
    curReq = "R5";
    for (int k = 0; k < 4; k++) hostPush(32'hC0000000 + k);
    idle(); coreRdReq = 1; coreRdSel = 0; hostInboxWr = 1; hostWrData = 32'hC0000010; cyc();
    idle(); cyc();

    // R4 overwrite newest when full
    curReq = "R4";
    hostPush(32'hD0000001); hostPush(32'hD0000002); cyc();
    for (int k = 0; k < 4; k++) coreRead(0);
    cyc(); cyc();

    // R6, R7, R8 outbound slots
    curReq = "R6";
    idle(); coreWrReq = 1; coreWrSel = 0; coreWrData = 32'hE0000001; cyc(); idle(); cyc();
    curReq = "R7";
    idle(); coreWrReq = 1; coreWrSel = 0; coreWrData = 32'hE0000002; cyc();
    hostOutRd = 2'b01; cyc();
    hostOutRd = 0; cyc(); idle(); cyc();
    curReq = "R8";
    idle(); coreWrReq = 1; coreWrSel = 1; coreWrData = 32'hE1000001; cyc(); idle(); cyc();
    hostOutRd = 2'b10; cyc(); idle(); cyc();
    hostOutRd = 2'b11; cyc(); idle(); cyc();

    // R9 replace mode
    curReq = "R9";
    idle(); sigOrMode = 0; hostSigWr = 2'b01; hostWrData = 32'h0000_0F00; cyc();
    hostWrData = 32'h0000_0033; cyc(); idle(); cyc();
    coreRead(1);
    hostSigWr = 2'b01; hostWrData = 0; cyc(); idle(); cyc();

    // R10 OR mode
    curReq = "R10";
    sigOrMode = 2'b10;
    idle(); hostSigWr = 2'b10; hostWrData = 32'h1; cyc();
    hostWrData = 32'h4; cyc(); hostWrData = 32'h100; cyc(); idle(); cyc();

    // R11 read clears, empty read stalls, select 3
    curReq = "R11";
    coreRead(2); coreRead(2); coreRead(1); coreRead(3); cyc();

    // R12 simultaneous write and read
    curReq = "R12";
    idle(); hostSigWr = 2'b11; hostWrData = 32'h0000_00F0; cyc(); idle();
    coreRdReq = 1; coreRdSel = 1; hostSigWr = 2'b01; hostWrData = 32'h0000_0005; cyc();
    sigOrMode = 2'b11;
    coreRdSel = 2; hostSigWr = 2'b10; hostWrData = 32'h0000_0007; cyc(); idle(); cyc();

    // mixed traffic against the model
    curReq = "R2";
    for (int n = 0; n < 400; n++) begin
      idle();
      sigOrMode   = 2'($urandom);
      hostWrData  = $urandom;
      coreWrData  = $urandom;
      hostInboxWr = ($urandom % 3) == 0;
      hostSigWr   = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      hostOutRd   = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 2) begin
        coreRdReq = 1; coreRdSel = 2'($urandom);
      end else if ($urandom % 2) begin
        coreWrReq = 1; coreWrSel = 1'($urandom);
      end
      cyc();
    end
    idle(); cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule